// File: doc/BRIEF.md
# Graphics Engine Interrupt Controller

This block collects three completion and fault events from a tile-based graphics engine and presents them to software through a small register file. The three events are: the binner has run out of overflow memory, the binner has flushed its last tile list, and the renderer has finished a frame. Each event owns one bit of a pending-status word. Software acknowledges a pending bit by writing a 1 to it. The enable mask is never written directly. One register only turns bits on, a second register only turns bits off, and a read of either one returns the mask. A single interrupt line is driven high while any pending bit is also enabled.

The flush and frame events are one-cycle pulses that the block latches. The out-of-memory bit is not latched. It shows whether the binner currently has an overflow pool. At reset there is no pool, so this bit reads as set. Software hands over a pool by writing its base address and then its size. The size write is the step that grants the pool. When the binner uses up the pool, it signals this with a pulse, and the bit sets again.

Top module: `gpu_irq_regs`

## Requirements
- R1: After reset, the enable mask, the latched pending bits, the pool address and the pool size are all zero, `irqOut` is low, and the status word reads 0x4 because no pool has been granted.
- R2: A write to the enable-set register (offset 1) sets every mask bit written as 1 and leaves every bit written as 0 unchanged.
- R3: A write to the enable-clear register (offset 2) clears every mask bit written as 1 and leaves every bit written as 0 unchanged.
- R4: A read at offset 1 and a read at offset 2 both return the current enable mask.
- R5: A pulse on `evtFrameDone` sets status bit 0, and a pulse on `evtFlushDone` sets status bit 1, whether or not the source is enabled. Writing a 1 to a status bit (offset 0) clears that bit. Writing a 0 leaves it unchanged.
- R6: If an event pulse and a write-1 acknowledge hit the same status bit in the same cycle, the bit ends up set.
- R7: Status bit 2 reads 1 whenever no overflow pool is held, and a write-1 acknowledge does not clear it. Any write to the pool-size register (offset 4) grants a pool and clears the bit. A `poolExhausted` pulse removes the pool and sets the bit again. If both happen in the same cycle, `poolExhausted` wins.
- R8: `irqOut` equals the OR over all bits of (status AND enable mask), as it stood one cycle earlier.
- R9: Mask bits above bit 2 read as zero and ignore writes. Offsets 5 to 7 read as zero. `regRdata` is zero whenever `regRd` is low.
- R10: The pool-address register (offset 3) and the pool-size register (offset 4) read back the full word last written to them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| regWr | input | 1 | Write strobe for the register bus |
| regRd | input | 1 | Read enable for the register bus |
| regAddr | input | ADDR_W | Word offset of the register |
| regWdata | input | DATA_W | Write data |
| regRdata | output | DATA_W | Read data, combinational from the address |
| evtFrameDone | input | 1 | One-cycle pulse when the renderer finishes a frame |
| evtFlushDone | input | 1 | One-cycle pulse when the binner flush completes |
| poolExhausted | input | 1 | One-cycle pulse when the binner has used up its overflow pool |
| irqOut | output | 1 | Registered interrupt request |

## Verification
The enable mask is tested with write patterns that mix 1s and 0s, including all-ones words. These separate the set-only and clear-only semantics from a plain overwrite, and they expose any leak into the unused bits. The pending bits are tested under several conditions: an event with its source masked, an event with its source enabled, an acknowledge on its own, and an acknowledge in the same cycle as an event. Together these separate latching from masking and show which side wins a collision. The out-of-memory bit goes through acknowledge while starved, a pool grant and an exhaustion pulse. This distinguishes a level-following bit from a latched one. Each change of `irqOut` is sampled exactly one cycle after the state change that causes it.

// File: rtl/gir_pkg.sv
package gir_pkg;
  localparam int NUM_SRC = 3;
  localparam int BIT_FRAME = 0;
  localparam int BIT_FLUSH = 1;
  localparam int BIT_OOM = 2;

  localparam int OFS_STATUS = 0;
  localparam int OFS_EN_SET = 1;
  localparam int OFS_EN_CLR = 2;
  localparam int OFS_POOL_ADDR = 3;
  localparam int OFS_POOL_SIZE = 4;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_STATUS,
    SEL_MASK,
    SEL_ADDR,
    SEL_SIZE
  } rdSel_e;

  typedef struct packed {
    logic ackStatus;
    logic maskSet;
    logic maskClr;
    logic wrAddr;
    logic wrSize;
  } regStrobe_t;
endpackage

// File: rtl/gir_ctrl.sv
module gir_ctrl
  import gir_pkg::*;
#(
  parameter int ADDR_W = 3
) (
  input  logic              regWr,
  input  logic              regRd,
  input  logic [ADDR_W-1:0] regAddr,
  output regStrobe_t        strobe,
  output rdSel_e            rdSel
);
  logic hitStatus, hitSet, hitClr, hitAddr, hitSize;

  always_comb begin
    hitStatus = (regAddr == ADDR_W'(OFS_STATUS));
    hitSet    = (regAddr == ADDR_W'(OFS_EN_SET));
    hitClr    = (regAddr == ADDR_W'(OFS_EN_CLR));
    hitAddr   = (regAddr == ADDR_W'(OFS_POOL_ADDR));
    hitSize   = (regAddr == ADDR_W'(OFS_POOL_SIZE));
  end

  always_comb begin
    strobe.ackStatus = regWr & hitStatus;
    strobe.maskSet   = regWr & hitSet;
    strobe.maskClr   = regWr & hitClr;
    strobe.wrAddr    = regWr & hitAddr;
    strobe.wrSize    = regWr & hitSize;
  end

  always_comb begin
    rdSel = SEL_NONE;
    if (regRd) begin
      if (hitStatus) rdSel = SEL_STATUS;
      else if (hitSet || hitClr) rdSel = SEL_MASK;
      else if (hitAddr) rdSel = SEL_ADDR;
      else if (hitSize) rdSel = SEL_SIZE;
    end
  end

  // Decoded write strobes never target two registers at once.
  always_comb begin
    if (regWr) begin
      assert ($onehot0({strobe.ackStatus, strobe.maskSet, strobe.maskClr,
                        strobe.wrAddr, strobe.wrSize}))  // R2
        else $error("AST_STROBE_ONEHOT");
    end
  end
endmodule

// File: rtl/gir_datapath.sv
module gir_datapath
  import gir_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  regStrobe_t        strobe,
  input  rdSel_e            rdSel,
  input  logic [DATA_W-1:0] regWdata,
  output logic [DATA_W-1:0] regRdata,
  input  logic              evtFrameDone,
  input  logic              evtFlushDone,
  input  logic              poolExhausted,
  output logic              irqOut
);
  localparam int PAD_W = DATA_W - NUM_SRC;

  logic [NUM_SRC-1:0] enMask;
  logic [NUM_SRC-1:0] eventIn;
  logic [NUM_SRC-1:0] latched;
  logic [NUM_SRC-1:0] statusVec;
  logic [NUM_SRC-1:0] setBits, clrBits, ackBits;
  logic               poolHeld;
  logic [DATA_W-1:0]  poolAddr, poolSize;
  logic               irqQ;

  always_comb begin
    eventIn            = '0;
    eventIn[BIT_FRAME] = evtFrameDone;
    eventIn[BIT_FLUSH] = evtFlushDone;
    setBits = strobe.maskSet   ? regWdata[NUM_SRC-1:0] : '0;
    clrBits = strobe.maskClr   ? regWdata[NUM_SRC-1:0] : '0;
    ackBits = strobe.ackStatus ? regWdata[NUM_SRC-1:0] : '0;
  end

  // Event-latched pending bits; the out-of-memory slot is level-driven.
  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    if (i == BIT_OOM) begin : g_level
      always_ff @(posedge clk) latched[i] <= 1'b0;
      assign statusVec[i] = ~poolHeld;
    end else begin : g_latch
      always_ff @(posedge clk) begin
        if (!rstN) latched[i] <= 1'b0;
        else       latched[i] <= eventIn[i] | (latched[i] & ~ackBits[i]);
      end
      assign statusVec[i] = latched[i];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      enMask   <= '0;
      poolHeld <= 1'b0;
      poolAddr <= '0;
      poolSize <= '0;
      irqQ     <= 1'b0;
    end else begin
      enMask <= (enMask | setBits) & ~clrBits;
      if (poolExhausted)     poolHeld <= 1'b0;
      else if (strobe.wrSize) poolHeld <= 1'b1;
      if (strobe.wrAddr) poolAddr <= regWdata;
      if (strobe.wrSize) poolSize <= regWdata;
      irqQ <= |(statusVec & enMask);
    end
  end

  assign irqOut = irqQ;

  always_comb begin
    unique case (rdSel)
      SEL_STATUS: regRdata = {{PAD_W{1'b0}}, statusVec};
      SEL_MASK:   regRdata = {{PAD_W{1'b0}}, enMask};
      SEL_ADDR:   regRdata = poolAddr;
      SEL_SIZE:   regRdata = poolSize;
      default:    regRdata = '0;
    endcase
  end

  AST_MASK_SET: assert property (@(posedge clk) disable iff (!rstN)
    strobe.maskSet |=> ((enMask & $past(regWdata[NUM_SRC-1:0])) == $past(regWdata[NUM_SRC-1:0]))) else $error("AST_MASK_SET");  // R2
  AST_MASK_CLR: assert property (@(posedge clk) disable iff (!rstN)
    strobe.maskClr |=> ((enMask & $past(regWdata[NUM_SRC-1:0])) == '0)) else $error("AST_MASK_CLR");  // R3
  AST_EVT_WINS: assert property (@(posedge clk) disable iff (!rstN)
    evtFlushDone |=> statusVec[BIT_FLUSH]) else $error("AST_EVT_WINS");  // R6
  AST_OOM_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (statusVec[BIT_OOM] && !strobe.wrSize) |=> statusVec[BIT_OOM]) else $error("AST_OOM_STICKY");  // R7
  AST_IRQ_FOLLOWS: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (irqOut == $past(|(statusVec & enMask)))) else $error("AST_IRQ_FOLLOWS");  // R8
endmodule

// File: rtl/gpu_irq_regs.sv
module gpu_irq_regs
  import gir_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWr,
  input  logic              regRd,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWdata,
  output logic [DATA_W-1:0] regRdata,
  input  logic              evtFrameDone,
  input  logic              evtFlushDone,
  input  logic              poolExhausted,
  output logic              irqOut
);
  regStrobe_t strobe;
  rdSel_e     rdSel;

  gir_ctrl #(.ADDR_W(ADDR_W)) i_ctrl (
    .regWr(regWr), .regRd(regRd), .regAddr(regAddr),
    .strobe(strobe), .rdSel(rdSel)
  );

  gir_datapath #(.DATA_W(DATA_W)) i_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .rdSel(rdSel),
    .regWdata(regWdata), .regRdata(regRdata),
    .evtFrameDone(evtFrameDone), .evtFlushDone(evtFlushDone),
    .poolExhausted(poolExhausted), .irqOut(irqOut)
  );
endmodule

// File: tb/test_gpu_irq_regs.sv
module test_gpu_irq_regs;
  localparam int DW = 32;
  localparam int AW = 3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic regWr = 1'b0, regRd = 1'b0;
  logic [AW-1:0] regAddr = '0;
  logic [DW-1:0] regWdata = '0;
  logic [DW-1:0] regRdata;
  logic evtFrameDone = 1'b0, evtFlushDone = 1'b0, poolExhausted = 1'b0;
  logic irqOut;
  int checks = 0, fails = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  gpu_irq_regs #(.DATA_W(DW), .ADDR_W(AW)) i_gpu_irq_regs (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regRd(regRd), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .evtFrameDone(evtFrameDone),
    .evtFlushDone(evtFlushDone), .poolExhausted(poolExhausted), .irqOut(irqOut)
  );

  // {isRead, addr, data}; for reads, data is the expected value.
  localparam int NV = 18;
  localparam logic [35:0] VEC [NV] = '{
    {1'b0, 3'd1, 32'h0000_0001},  // R2 set bit0
    {1'b1, 3'd1, 32'h0000_0001},  // R2
    {1'b0, 3'd1, 32'h0000_0004},  // R2 set bit2
    {1'b1, 3'd2, 32'h0000_0005},  // R4 read via clear offset
    {1'b0, 3'd1, 32'h0000_0000},  // R2 zeros change nothing
    {1'b1, 3'd1, 32'h0000_0005},  // R2
    {1'b0, 3'd2, 32'h0000_0001},  // R3 clear bit0
    {1'b1, 3'd1, 32'h0000_0004},  // R3
    {1'b0, 3'd2, 32'h0000_0000},  // R3 zeros change nothing
    {1'b1, 3'd2, 32'h0000_0004},  // R3
    {1'b0, 3'd1, 32'hFFFF_FFFF},  // R9 high bits ignored
    {1'b1, 3'd1, 32'h0000_0007},  // R9
    {1'b0, 3'd2, 32'hFFFF_FFFF},  // R3 clear all
    {1'b1, 3'd1, 32'h0000_0000},  // R3
    {1'b0, 3'd3, 32'hA5C3_0040},  // R10 pool address
    {1'b1, 3'd3, 32'hA5C3_0040},  // R10
    {1'b1, 3'd5, 32'h0000_0000},  // R9 unmapped
    {1'b1, 3'd7, 32'h0000_0000}   // R9 unmapped
  };

  task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic busWr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    regWr = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk);
    regWr = 1'b0; regWdata = '0;
  endtask

  task automatic busRd(input string tag, input logic [AW-1:0] a, input logic [DW-1:0] e);
    @(negedge clk);
    regRd = 1'b1; regAddr = a;
    #1 check(tag, regRdata, e);
    regRd = 1'b0;
  endtask

  task automatic pulse(input int which);
    @(negedge clk);
    if (which == 0) evtFrameDone = 1'b1;
    else if (which == 1) evtFlushDone = 1'b1;
    else poolExhausted = 1'b1;
    @(negedge clk);
    evtFrameDone = 1'b0; evtFlushDone = 1'b0; poolExhausted = 1'b0;
  endtask

  // One more edge so the registered interrupt reflects the new state.
  task automatic irqChk(input string tag, input logic e);
    @(negedge clk);
    check(tag, {31'd0, irqOut}, {31'd0, e});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    busRd("R1 status", 3'd0, 32'h4);
    busRd("R1 mask", 3'd1, 32'h0);
    busRd("R1 addr", 3'd3, 32'h0);
    busRd("R1 size", 3'd4, 32'h0);
    check("R1 irq", {31'd0, irqOut}, 32'd0);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][35]) busRd($sformatf("table R2/R3/R4/R9/R10 entry %0d", i), VEC[i][34:32], VEC[i][31:0]);
      else busWr(VEC[i][34:32], VEC[i][31:0]);
    end

    // R9: no read enable gives zero data
    @(negedge clk); regAddr = 3'd3; #1 check("R9 no read", regRdata, 32'h0);

    // R5: masked events still latch; acknowledge clears
    pulse(1);
    busRd("R5 flush latched", 3'd0, 32'h6);
    irqChk("R8 masked no irq", 1'b0);
    busWr(3'd0, 32'h2);
    busRd("R5 ack cleared", 3'd0, 32'h4);
    pulse(0);
    busRd("R5 frame latched", 3'd0, 32'h5);
    busWr(3'd0, 32'h0);
    busRd("R5 zero ack keeps", 3'd0, 32'h5);

    // R8: enabling a pending source raises irq one cycle later
    busWr(3'd1, 32'h1);
    check("R8 irq not yet", {31'd0, irqOut}, 32'd0);
    irqChk("R8 irq raised", 1'b1);
    busWr(3'd0, 32'h1);
    irqChk("R8 irq dropped", 1'b0);

    // R6: event and acknowledge in the same cycle
    @(negedge clk);
    regWr = 1'b1; regAddr = 3'd0; regWdata = 32'h2; evtFlushDone = 1'b1;
    @(negedge clk);
    regWr = 1'b0; regWdata = '0; evtFlushDone = 1'b0;
    busRd("R6 event wins", 3'd0, 32'h6);
    busWr(3'd0, 32'h2);

    // R7: out-of-memory follows the pool state
    busWr(3'd0, 32'h4);
    busRd("R7 ack while starved", 3'd0, 32'h4);
    busWr(3'd1, 32'h4);
    irqChk("R8 oom irq", 1'b1);
    busWr(3'd4, 32'h0000_2000);
    busRd("R7 pool granted", 3'd0, 32'h0);
    busRd("R10 size readback", 3'd4, 32'h0000_2000);
    irqChk("R8 oom irq gone", 1'b0);
    pulse(2);
    busRd("R7 pool exhausted", 3'd0, 32'h4);
    irqChk("R8 oom irq back", 1'b1);
    @(negedge clk);
    regWr = 1'b1; regAddr = 3'd4; regWdata = 32'h100; poolExhausted = 1'b1;
    @(negedge clk);
    regWr = 1'b0; regWdata = '0; poolExhausted = 1'b0;
    busRd("R7 exhaust beats grant", 3'd0, 32'h4);

    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule